// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of an 8051-style multiplexed external memory bus: an address-latch pulse, active high, and an active-low read strobe for program memory. It runs a free-running machine-cycle sequencer from the oscillator clock. Each machine cycle is six states of two clocks each. The strobes are decoded from the current state and from a small set of per-cycle flags.

The core drives these flags from its instruction flow: a data-transfer flag for a cycle that moves a byte over the bus to external data memory, a table-read flag for a code-constant read, and an external-fetch flag for execution from external program memory. The block samples them once per machine cycle. A single configuration bit, written through a byte-addressed register write port, can silence the latch pulse outside bus transfers. That bit does not apply while code is fetched externally.

Top module: `xbus_strobe_gen`

## Requirements
- R1: A machine cycle lasts 12 clocks. Counting its first clock as index 0, `ale_o` is high at indices 0–1 (state 1) and 6–7 (state 4) and low elsewhere. This gives two pulses per cycle, a rate of one sixth of the clock.
- R2: When the cycle's external-fetch flag is 1 and its data flag is 0, `psen_n_o` is low at indices 4–7 (states 3–4) and 10–11 (state 6). It is also low at indices 0–1 of the following cycle. It is high at all other times.
- R3: `xdata_i`, `cread_i` and `ext_fetch_i` are sampled only at the clock edge that starts a machine cycle. Changing them later in the cycle does not change the strobes of that cycle.
- R4: In a cycle whose data flag is 1, the state-1 latch pulse is dropped and the state-4 pulse is kept.
- R5: In a cycle whose data flag is 1, `psen_n_o` stays high. This removes both read pulses: states 3–4, and states 6 through the next cycle's state 1.
- R6: A write with `reg_addr_i` equal to 8'h8E stores `reg_wbit_i` as the ALE-disable bit, and the write acts from the edge that performs it. While the bit is 1 and external fetch is off, `ale_o` stays low unless the cycle's data flag or table-read flag is 1.
- R7: While the cycle's external-fetch flag is 1, the ALE-disable bit has no effect, and both latch pulses follow R1 and R4.
- R8: A write to any other address does not change the ALE-disable bit.
- R9: While `rst_n` is low, `ale_o` is 0 and `psen_n_o` is 1. Reset clears the disable bit and the carried state-6 read pulse. The first edge after release starts machine cycle index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xdata_i | input | 1 | Cycle carries an external data transfer |
| cread_i | input | 1 | Cycle performs a code-table read |
| ext_fetch_i | input | 1 | Code is fetched from external program memory |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wbit_i | input | 1 | Value written into the disable bit |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-read strobe, active low |

## Verification
A sequencer that slips by one clock moves every latch and read pulse by one index. The first sampled cycle after reset shows this at once. Flags latched at the wrong edge show up within the same machine cycle, as read windows that open or close part-way through. A disable bit or carry register holding the wrong value shows up in the next machine cycle: a missing or extra pulse at index 0 or 6.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;

   localparam int unsigned MC_STATES = 6;
   localparam int unsigned ST_W      = 3;

   // state numbering used by the decoder: 0 is the first state of a cycle
   localparam logic [ST_W-1:0] ST_FIRST  = 3'd0;
   localparam logic [ST_W-1:0] ST_READ_A = 3'd2;
   localparam logic [ST_W-1:0] ST_MID    = 3'd3;
   localparam logic [ST_W-1:0] ST_LAST   = 3'd5;

   typedef struct packed {
      logic xdata;   // data transfer cycle
      logic cread;   // code-table read cycle
      logic fetch;   // external code fetch
      logic tail;    // previous cycle opened a state-6 read pulse
      logic dis;     // latch strobe disable bit
   } mc_flags_t;

endpackage

// File: rtl/xbus_mc_timer.sv
module xbus_mc_timer
   import xbus_strobe_pkg::*;
#(
   parameter int unsigned CLKS_PER_STATE = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [ST_W-1:0] st_q,
   output logic [ST_W-1:0] st_nxt,
   output logic            boundary
);

   localparam int unsigned TW = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1;
   localparam logic [TW-1:0] TICK_LAST = TW'(CLKS_PER_STATE - 1);

   logic [TW-1:0] tick_q;
   logic [TW-1:0] tick_nxt;
   logic          last_tick;

   always_comb begin
      last_tick = (tick_q == TICK_LAST);
      tick_nxt  = last_tick ? '0 : tick_q + TW'(1);
      if (!last_tick)
         st_nxt = st_q;
      else if (st_q == ST_LAST)
         st_nxt = ST_FIRST;
      else
         st_nxt = st_q + ST_W'(1);
      boundary = last_tick && (st_q == ST_LAST);
   end

   // reset parks the sequencer on the final clock so release begins a cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_LAST;
         tick_q <= TICK_LAST;
      end else begin
         st_q   <= st_nxt;
         tick_q <= tick_nxt;
      end
   end

endmodule

// File: rtl/xbus_mc_flags.sv
module xbus_mc_flags
   import xbus_strobe_pkg::*;
#(
   parameter logic [7:0] DIS_ADDR = 8'h8E
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      boundary,
   input  logic      xdata_i,
   input  logic      cread_i,
   input  logic      ext_fetch_i,
   input  logic      reg_we_i,
   input  logic [7:0] reg_addr_i,
   input  logic      reg_wbit_i,
   output mc_flags_t flg_q,
   output mc_flags_t flg_nxt
);

   always_comb begin
      flg_nxt = flg_q;
      if (reg_we_i && (reg_addr_i == DIS_ADDR))
         flg_nxt.dis = reg_wbit_i;
      if (boundary) begin
         flg_nxt.tail  = flg_q.fetch && !flg_q.xdata;
         flg_nxt.xdata = xdata_i;
         flg_nxt.cread = cread_i;
         flg_nxt.fetch = ext_fetch_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flg_q <= '0;
      else
         flg_q <= flg_nxt;
   end

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
   import xbus_strobe_pkg::*;
(
   input  logic [ST_W-1:0] st,
   input  mc_flags_t       flg,
   output logic            ale,
   output logic            psen_n
);

   logic ale_ok;
   logic read_on;

   always_comb begin
      ale_ok  = flg.fetch || !flg.dis || flg.xdata || flg.cread;
      read_on = flg.fetch && !flg.xdata;
      ale     = 1'b0;
      psen_n  = 1'b1;
      unique case (st)
         ST_FIRST: begin
            ale    = ale_ok && !flg.xdata;
            psen_n = !flg.tail;
         end
         ST_READ_A: psen_n = !read_on;
         ST_MID: begin
            ale    = ale_ok;
            psen_n = !read_on;
         end
         ST_LAST: psen_n = !read_on;
         default: ;
      endcase
   end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
   import xbus_strobe_pkg::*;
#(
   parameter int unsigned CLKS_PER_STATE = 2,
   parameter logic [7:0]  DIS_ADDR       = 8'h8E,
   parameter bit          REG_OUT        = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xdata_i,
   input  logic       cread_i,
   input  logic       ext_fetch_i,
   input  logic       reg_we_i,
   input  logic [7:0] reg_addr_i,
   input  logic       reg_wbit_i,
   output logic       ale_o,
   output logic       psen_n_o
);

   if (CLKS_PER_STATE < 1) begin : g_bad_cps
      $error("CLKS_PER_STATE must be at least 1");
   end

   logic [ST_W-1:0] st_q;
   logic [ST_W-1:0] st_nxt;
   logic            boundary;
   mc_flags_t       flg_q;
   mc_flags_t       flg_nxt;

   xbus_mc_timer #(.CLKS_PER_STATE(CLKS_PER_STATE)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_q     (st_q),
      .st_nxt   (st_nxt),
      .boundary (boundary)
   );

   xbus_mc_flags #(.DIS_ADDR(DIS_ADDR)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary    (boundary),
      .xdata_i     (xdata_i),
      .cread_i     (cread_i),
      .ext_fetch_i (ext_fetch_i),
      .reg_we_i    (reg_we_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wbit_i  (reg_wbit_i),
      .flg_q       (flg_q),
      .flg_nxt     (flg_nxt)
   );

   if (REG_OUT) begin : g_reg_out
      // decode the values the next edge loads, then register: glitch-free pins
      logic ale_d;
      logic psen_n_d;

      xbus_strobe_dec u_dec (
         .st     (st_nxt),
         .flg    (flg_nxt),
         .ale    (ale_d),
         .psen_n (psen_n_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ale_o    <= 1'b0;
            psen_n_o <= 1'b1;
         end else begin
            ale_o    <= ale_d;
            psen_n_o <= psen_n_d;
         end
      end
   end else begin : g_comb_out
      xbus_strobe_dec u_dec (
         .st     (st_q),
         .flg    (flg_q),
         .ale    (ale_o),
         .psen_n (psen_n_o)
      );
   end

endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk
   import xbus_strobe_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            ale_o,
   input logic            psen_n_o,
   input logic [ST_W-1:0] st_q,
   input mc_flags_t       flg_q,
   input logic            boundary
);

   // R1: latch pulses only in the first and fourth state
   a_r1_ale_states: assert property (@(posedge clk) disable iff (!rst_n)
      ale_o |-> (st_q == ST_FIRST || st_q == ST_MID));

   // R2: read strobe only in its windows
   a_r2_psen_states: assert property (@(posedge clk) disable iff (!rst_n)
      !psen_n_o |-> (st_q == ST_FIRST || st_q == ST_READ_A ||
                     st_q == ST_MID || st_q == ST_LAST));

   // R3: cycle flags move only at the cycle boundary
   a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable({flg_q.xdata, flg_q.cread, flg_q.fetch, flg_q.tail}));

   // R4: data cycle drops the state-1 latch pulse
   a_r4_xdata_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q.xdata && st_q == ST_FIRST) |-> !ale_o);

   // R5: data cycle holds the read strobe inactive after state 1
   a_r5_xdata_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q.xdata && st_q != ST_FIRST) |-> psen_n_o);

   // R6: disabled latch strobe stays low outside bus transfers
   a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q.dis && !flg_q.fetch && !flg_q.xdata && !flg_q.cread) |-> !ale_o);

endmodule

bind xbus_strobe_gen xbus_strobe_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ale_o    (ale_o),
   .psen_n_o (psen_n_o),
   .st_q     (st_q),
   .flg_q    (flg_q),
   .boundary (boundary)
);

// File: tb/xbus_strobe_gen_tb.sv
module xbus_strobe_gen_tb;

   localparam time TCLK = 20ns;
   localparam int unsigned NVEC = 14;
   localparam logic [7:0] DIS_A = 8'h8E;

   // {mid, we, addr[7:0], wbit, xd, mc, fe}
   localparam logic [13:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
      {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
      {1'b0, 1'b1, DIS_A, 1'b1, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
      {1'b0, 1'b1, DIS_A, 1'b0, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b1, 8'h8F, 1'b1, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b1, 8'h0E, 1'b1, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b1, DIS_A, 1'b1, 1'b1, 1'b0, 1'b1},
      {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xdata_i = 1'b0;
   logic       cread_i = 1'b0;
   logic       ext_fetch_i = 1'b0;
   logic       reg_we_i = 1'b0;
   logic [7:0] reg_addr_i = 8'h00;
   logic       reg_wbit_i = 1'b0;
   logic       ale_o;
   logic       psen_n_o;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic dis_m = 1'b0;
   logic tail_m = 1'b0;

   always #(TCLK/2) clk = ~clk;

   xbus_strobe_gen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .xdata_i     (xdata_i),
      .cread_i     (cread_i),
      .ext_fetch_i (ext_fetch_i),
      .reg_we_i    (reg_we_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wbit_i  (reg_wbit_i),
      .ale_o       (ale_o),
      .psen_n_o    (psen_n_o)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // called at the falling edge just before a machine-cycle boundary
   task automatic run_mc(input logic we, input logic [7:0] addr, input logic wb,
                         input logic xd, input logic mc, input logic fe,
                         input logic mid, input string tag_ovr);
      string tag_a;
      string tag_p;
      reg_we_i    = we;
      reg_addr_i  = addr;
      reg_wbit_i  = wb;
      xdata_i     = xd;
      cread_i     = mc;
      ext_fetch_i = fe;
      if (we && addr == DIS_A) dis_m = wb;
      if (tag_ovr != "")            tag_a = tag_ovr;
      else if (we && addr != DIS_A) tag_a = "R8";
      else if (xd)                  tag_a = "R4";
      else if (dis_m && fe)         tag_a = "R7";
      else if (dis_m)               tag_a = "R6";
      else                          tag_a = "R1";
      tag_p = (tag_ovr != "") ? tag_ovr : (xd ? "R5" : "R2");
      for (int k = 0; k < 12; k++) begin
         int   s;
         logic ok;
         logic e_ale;
         logic e_psn;
         @(negedge clk);
         if (k == 0) reg_we_i = 1'b0;
         s  = k / 2;
         ok = fe | ~dis_m | xd | mc;
         e_ale = (s == 0 && ok && !xd) || (s == 3 && ok);
         if (s == 0)                        e_psn = ~tail_m;
         else if (s == 2 || s == 3 || s == 5) e_psn = ~(fe & ~xd);
         else                               e_psn = 1'b1;
         chk(tag_a, $sformatf("ale idx %0d", k), ale_o, e_ale);
         chk(tag_p, $sformatf("psen_n idx %0d", k), psen_n_o, e_psn);
         if (mid && k == 4) begin
            xdata_i     = ~xd;
            cread_i     = ~mc;
            ext_fetch_i = ~fe;
         end
      end
      tail_m = fe & ~xd;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", "ale in reset", ale_o, 1'b0);
      chk("R9", "psen_n in reset", psen_n_o, 1'b1);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [13:0] v;
         v = VEC[i];
         run_mc(v[12], v[11:4], v[3], v[2], v[1], v[0], v[13], v[13] ? "R3" : "");
      end

      // carried read pulse pending, disable bit set, then reset mid-run
      run_mc(1'b1, DIS_A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9", "ale after reset", ale_o, 1'b0);
      chk("R9", "psen_n after reset", psen_n_o, 1'b1);
      rst_n  = 1'b1;
      dis_m  = 1'b0;
      tail_m = 1'b0;
      run_mc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
      run_mc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(TCLK * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (R1 sequencing): actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule